// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Almost Flags

This block is a first-in first-out buffer of 512 words of 9 bits. The write side and the read side each run on their own clock. The two clocks may be the same net or may have no phase or frequency relation at all. A word is stored when both write enables are active. The read side returns words in the order they were stored, through a registered output. An output-enable input gates that output to zero when it is low.

All four status flags are active low:

- `empty_n` and `aempty_n` belong to the read clock.
- `full_n` and `afull_n` belong to the write clock.

The almost flags compare the fill level against two offsets. Both offsets reset to 7. They are reloaded by raising `ofs_ld` during write-enabled cycles. The first such word sets the empty offset and the next sets the full offset, after which the order repeats.

Pointers cross between the clock domains as Gray code through two-flop synchronizers. Each flag can therefore be late to clear after activity on the far side. A flag is never late to assert.

Top module: `dcfifo_prog`

## Requirements
- R1: While `rst` (active high, synchronous) is sampled high by both clocks, the block clears. After that, `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, and `dout`=0.
- R2: A word is stored on a rising `wclk` edge only when `wen_n`=0, `wen_hi`=1 and `ofs_ld`=0. Any other enable combination stores nothing.
- R3: A word is read on a rising `rclk` edge when `ren_n`=0 and `ren_hi`=1. The word is on `dout` after that edge, and words leave in the order they were stored.
- R4: `full_n` is 0 exactly while 512 words are held. A write attempted while `full_n`=0 is dropped.
- R5: A read attempted while `empty_n`=0 is dropped, and `dout` keeps its previous value.
- R6: `empty_n` is 0 while no word is visible to the read side. With tied clocks, it rises on the third `rclk` edge after the edge that stored the first word.
- R7: Once the two sides have settled, `aempty_n` is 0 exactly while the fill level is at most the empty offset. The reset value of the empty offset is 7.
- R8: Once the two sides have settled, `afull_n` is 0 exactly while the fill level is at least 512 minus the full offset. With the reset value of 7, it asserts at 505 words.
- R9: A cycle with `ofs_ld`=1, `wen_n`=0 and `wen_hi`=1 loads `din` into an offset register and leaves the storage and fill level unchanged. Successive load cycles alternate between the empty offset (first after reset) and the full offset.
- R10: With `oe`=0, `dout` is 0 and `dout_en` is 0. With `oe`=1, `dout` shows the output register and `dout_en` is 1.
- R11: With independent, unrelated clocks, all data arrives intact and in order. Once traffic stops, every flag settles to the value given by the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, tied to `wclk` or independent |
| rst | input | 1 | Synchronous active-high clear, seen by both clocks |
| wen_n | input | 1 | Write enable, active low |
| wen_hi | input | 1 | Write enable, active high |
| ofs_ld | input | 1 | Steers enabled write cycles into the offset registers |
| din | input | 9 | Write data, or offset value during loads |
| ren_n | input | 1 | Read enable, active low |
| ren_hi | input | 1 | Read enable, active high |
| oe | input | 1 | Output enable; low forces `dout` to zero |
| dout | output | 9 | Read data |
| dout_en | output | 1 | High when `dout` carries data |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The assertions take the following for granted:

- Offsets are reloaded only while the buffer is empty and neither side is moving. The read domain uses the empty offset without synchronizing it.
- `rst` stays high across several edges of both clocks.
- The depth is a power of two.

The stimulus keeps within these limits. Loads are issued only in idle, drained windows, and each reset is held for four edges of each clock. Random traffic is run first with tied clocks and then with an 11 ns read clock against the 8 ns write clock. Enable combinations are drawn at random, including the inactive ones.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  // which offset register the next load cycle targets
  typedef enum logic {SEL_EMPTY_OFS = 1'b0, SEL_FULL_OFS = 1'b1} ofs_sel_e;
  localparam int unsigned DEF_OFS = 7;
endpackage

// File: rtl/dcfifo_gsync.sv
// Carries a Gray-coded pointer into another clock domain and returns it in binary.
module dcfifo_gsync #(
  parameter int PW     = 10,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    bin_out[PW-1] = stg[STAGES-1][PW-1];
    for (int i = PW - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/dcfifo_ram.sv
// Simple dual-port storage with a registered read, shaped for block RAM inference.
module dcfifo_ram #(
  parameter int W  = 9,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int N = 2 ** AW;
  logic [W-1:0] mem [N];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcfifo_wctl.sv
// Write-domain control: pointer, full and almost-full flags, offset registers.
module dcfifo_wctl
  import dcfifo_pkg::*;
#(
  parameter int W     = 9,
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wen_n,
  input  logic          wen_hi,
  input  logic          ofs_ld,
  input  logic [W-1:0]  din,
  input  logic [PW-1:0] rbin_s,
  output logic          wr_fire,
  output logic [PW-1:0] wbin,
  output logic [PW-1:0] wgray,
  output logic          full_n,
  output logic          afull_n,
  output logic [AW-1:0] ofs_e
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic          wr_req, ld_fire;
  logic [PW-1:0] wbin_nxt, wcnt_nxt;
  logic [AW-1:0] ofs_f;
  ofs_sel_e      sel;

  assign wr_req   = !wen_n && wen_hi;
  assign ld_fire  = wr_req && ofs_ld;
  assign wr_fire  = wr_req && !ofs_ld && full_n;
  assign wbin_nxt = wbin + PW'(wr_fire);
  assign wcnt_nxt = wbin_nxt - rbin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      ofs_e   <= AW'(DEF_OFS);
      ofs_f   <= AW'(DEF_OFS);
      sel     <= SEL_EMPTY_OFS;
    end else begin
      wbin    <= wbin_nxt;
      wgray   <= wbin_nxt ^ (wbin_nxt >> 1);
      full_n  <= (wcnt_nxt != DEPTH_P);
      afull_n <= (wcnt_nxt < (DEPTH_P - PW'(ofs_f)));
      if (ld_fire) begin
        if (sel == SEL_EMPTY_OFS) ofs_e <= AW'(din);
        else                      ofs_f <= AW'(din);
        sel <= (sel == SEL_EMPTY_OFS) ? SEL_FULL_OFS : SEL_EMPTY_OFS;
      end
    end
  end

  // R4
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_s) <= DEPTH_P);
  // R4
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    !full_n |=> $stable(wbin));
  // R11
  wgray_one_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R8
  full_implies_afull_chk: assert property (@(posedge clk) disable iff (rst)
    !full_n |-> !afull_n);
  // R9
  load_keeps_pointer_chk: assert property (@(posedge clk) disable iff (rst)
    ofs_ld |=> $stable(wbin));
endmodule

// File: rtl/dcfifo_rctl.sv
// Read-domain control: pointer, empty and almost-empty flags.
module dcfifo_rctl #(
  parameter int DEPTH = 512,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_n,
  input  logic          ren_hi,
  input  logic [PW-1:0] wbin_s,
  input  logic [AW-1:0] ofs_e,
  output logic          rd_fire,
  output logic [PW-1:0] rbin,
  output logic [PW-1:0] rgray,
  output logic          empty_n,
  output logic          aempty_n
);
  logic [PW-1:0] rbin_nxt, rcnt_nxt;

  assign rd_fire  = !ren_n && ren_hi && empty_n;
  assign rbin_nxt = rbin + PW'(rd_fire);
  assign rcnt_nxt = wbin_s - rbin_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nxt;
      rgray    <= rbin_nxt ^ (rbin_nxt >> 1);
      empty_n  <= (rcnt_nxt != '0);
      aempty_n <= (rcnt_nxt > PW'(ofs_e));
    end
  end

  // R5
  no_read_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !empty_n |=> $stable(rbin));
  // R7
  empty_implies_aempty_chk: assert property (@(posedge clk) disable iff (rst)
    !empty_n |-> !aempty_n);
  // R11
  rgray_one_step_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R11
  read_not_past_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wbin_s - rbin) <= PW'(DEPTH));
endmodule

// File: rtl/dcfifo_prog.sv
module dcfifo_prog #(
  parameter int W      = 9,
  parameter int DEPTH  = 512,
  parameter int STAGES = 2
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst,
  input  logic         wen_n,
  input  logic         wen_hi,
  input  logic         ofs_ld,
  input  logic [W-1:0] din,
  input  logic         ren_n,
  input  logic         ren_hi,
  input  logic         oe,
  output logic [W-1:0] dout,
  output logic         dout_en,
  output logic         empty_n,
  output logic         aempty_n,
  output logic         full_n,
  output logic         afull_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_fire, rd_fire;
  logic [PW-1:0] wbin, wgray, rbin, rgray, wbin_s, rbin_s;
  logic [AW-1:0] ofs_e;
  logic [W-1:0]  rdata;

  dcfifo_wctl #(.W(W), .DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wctl (
    .clk(wclk), .rst(rst), .wen_n(wen_n), .wen_hi(wen_hi), .ofs_ld(ofs_ld),
    .din(din), .rbin_s(rbin_s), .wr_fire(wr_fire), .wbin(wbin), .wgray(wgray),
    .full_n(full_n), .afull_n(afull_n), .ofs_e(ofs_e)
  );

  dcfifo_rctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rctl (
    .clk(rclk), .rst(rst), .ren_n(ren_n), .ren_hi(ren_hi), .wbin_s(wbin_s),
    .ofs_e(ofs_e), .rd_fire(rd_fire), .rbin(rbin), .rgray(rgray),
    .empty_n(empty_n), .aempty_n(aempty_n)
  );

  dcfifo_gsync #(.PW(PW), .STAGES(STAGES)) u_w2r (
    .clk(rclk), .rst(rst), .gray_in(wgray), .bin_out(wbin_s)
  );

  dcfifo_gsync #(.PW(PW), .STAGES(STAGES)) u_r2w (
    .clk(wclk), .rst(rst), .gray_in(rgray), .bin_out(rbin_s)
  );

  dcfifo_ram #(.W(W), .AW(AW)) u_ram (
    .wclk(wclk), .we(wr_fire), .waddr(wbin[AW-1:0]), .wdata(din),
    .rclk(rclk), .rst(rst), .re(rd_fire), .raddr(rbin[AW-1:0]), .rdata(rdata)
  );

  assign dout    = oe ? rdata : '0;
  assign dout_en = oe;

  // R3
  dout_moves_only_on_read_chk: assert property (@(posedge rclk) disable iff (rst)
    (oe && $past(oe) && !$past(rd_fire)) |-> $stable(dout));
endmodule

// File: tb/sim_dcfifo_prog.sv
`timescale 1ns/1ps
module sim_dcfifo_prog;
  localparam int DEPTH = 512;

  logic wclk = 0, rclk_free = 0, tied = 1;
  logic rclk;
  logic rst = 1, wen_n = 1, wen_hi = 0, ofs_ld = 0, ren_n = 1, ren_hi = 0, oe = 1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_en, empty_n, aempty_n, full_n, afull_n;

  always #4 wclk = ~wclk;
  always #5.5 rclk_free = ~rclk_free;
  assign rclk = tied ? wclk : rclk_free;

  dcfifo_prog u0 (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wen_n(wen_n), .wen_hi(wen_hi),
    .ofs_ld(ofs_ld), .din(din), .ren_n(ren_n), .ren_hi(ren_hi), .oe(oe),
    .dout(dout), .dout_en(dout_en), .empty_n(empty_n), .aempty_n(aempty_n),
    .full_n(full_n), .afull_n(afull_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [8:0] q[$];
  int ofs_e_m = 7, ofs_f_m = 7;
  bit sel_m = 0;
  logic [8:0] last_m = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic wn, input logic wh, input logic ld, input logic [8:0] d);
    bit req, fw, fl;
    @(negedge wclk);
    wen_n = wn; wen_hi = wh; ofs_ld = ld; din = d;
    req = !wn && wh;
    fw = req && !ld && full_n;
    fl = req && ld;
    @(posedge wclk);
    #1 wen_n = 1; wen_hi = 0; ofs_ld = 0;
    if (fw) q.push_back(d);
    if (fl) begin
      if (!sel_m) ofs_e_m = d; else ofs_f_m = d;
      sel_m = !sel_m;
    end
  endtask

  task automatic rd_raw(input logic rn, input logic rh);
    bit fire;
    logic [8:0] exp;
    @(negedge rclk);
    ren_n = rn; ren_hi = rh;
    fire = !rn && rh && empty_n;
    @(posedge rclk);
    #1 ren_n = 1; ren_hi = 0;
    if (fire) begin
      if (q.size() == 0) check(0, "R3 read with empty model", int'(dout), -1);
      else begin
        exp = q.pop_front();
        check(dout == exp, "R3 order", int'(dout), int'(exp));
        last_m = exp;
      end
    end else if (!rn && rh) begin
      check(dout == last_m, "R5 ignored read", int'(dout), int'(last_m));
    end
  endtask

  task automatic settle(input string tag);
    int n;
    repeat (8) @(posedge wclk);
    repeat (8) @(posedge rclk);
    n = q.size();
    @(negedge rclk);
    check(empty_n == (n != 0), {tag, " R6 empty_n"}, int'(empty_n), int'(n != 0));
    check(aempty_n == (n > ofs_e_m), {tag, " R7 aempty_n"}, int'(aempty_n), int'(n > ofs_e_m));
    @(negedge wclk);
    check(full_n == (n != DEPTH), {tag, " R4 full_n"}, int'(full_n), int'(n != DEPTH));
    check(afull_n == (n < DEPTH - ofs_f_m), {tag, " R8 afull_n"}, int'(afull_n),
          int'(n < DEPTH - ofs_f_m));
  endtask

  task automatic fill_to(input int n);
    while (q.size() < n) wr_raw(0, 1, 0, 9'($urandom));
  endtask

  task automatic drain();
    while (q.size() > 0) rd_raw(0, 1);
  endtask

  task automatic do_reset(input logic tie);
    rst = 1; tied = tie;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    q.delete(); ofs_e_m = 7; ofs_f_m = 7; sel_m = 0; last_m = '0;
    @(negedge rclk);
    check(empty_n == 0 && aempty_n == 0, "R1 read flags", int'({empty_n, aempty_n}), 0);
    check(dout == 0, "R1 dout", int'(dout), 0);
    @(negedge wclk);
    check(full_n == 1 && afull_n == 1, "R1 write flags", int'({full_n, afull_n}), 3);
    rst = 0;
  endtask

  task automatic random_mix(input int ops);
    fork
      begin
        for (int i = 0; i < ops; i++)
          wr_raw(($urandom % 5) == 0, ($urandom % 5) != 0, 0, 9'($urandom));
      end
      begin
        for (int i = 0; i < ops; i++)
          rd_raw(($urandom % 4) == 0, ($urandom % 3) != 0);
      end
    join
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'd4711));
    do_reset(1);

    // R5: reads on an empty buffer are dropped
    rd_raw(0, 1); rd_raw(0, 1);
    // R2: inactive enable combinations store nothing
    wr_raw(1, 1, 0, 9'h11); wr_raw(0, 0, 0, 9'h12); wr_raw(1, 0, 0, 9'h13);
    settle("R2");

    // R6: latency of empty_n with tied clocks
    wr_raw(0, 1, 0, 9'h1A5);
    lat = 0;
    while (!empty_n && lat < 10) begin @(posedge rclk); #1; lat++; end
    check(lat == 3, "R6 empty latency", lat, 3);
    drain();

    // R7/R8: default thresholds
    fill_to(7);   settle("R7 at 7");
    fill_to(8);   settle("R7 at 8");
    fill_to(504); settle("R8 at 504");
    fill_to(505); settle("R8 at 505");
    fill_to(512); settle("R4 full");
    // R4: writes while full are dropped
    wr_raw(0, 1, 0, 9'h0AA); wr_raw(0, 1, 0, 9'h0BB);
    settle("R4 after extra");
    drain(); settle("R3 drained");

    // R10: output enable
    oe = 0; #1;
    check(dout == 0 && dout_en == 0, "R10 oe low", int'({dout_en, dout}), 0);
    oe = 1; #1;
    check(dout == last_m && dout_en == 1, "R10 oe high", int'({dout_en, dout}),
          int'({1'b1, last_m}));

    // R9: load offsets, empty first then full
    wr_raw(0, 1, 1, 9'd20);
    wr_raw(0, 1, 1, 9'd100);
    settle("R9 after load");
    fill_to(20);  settle("R9 at 20");
    fill_to(21);  settle("R9 at 21");
    fill_to(411); settle("R9 at 411");
    fill_to(412); settle("R9 at 412");
    drain();
    wr_raw(0, 1, 1, 9'd7);
    wr_raw(0, 1, 1, 9'd7);
    check(ofs_e_m == 7 && ofs_f_m == 7, "R9 model restore", ofs_e_m, 7);
    settle("R9 restored");

    // random traffic, tied clocks
    random_mix(3000);
    settle("R3 tied mix");
    drain(); settle("R3 tied drained");

    // R11: independent clocks
    do_reset(0);
    random_mix(3000);
    settle("R11 async mix");
    fill_to(200);
    random_mix(1500);
    settle("R11 async mix2");
    drain(); settle("R11 async drained");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule